// File: doc/BRIEF.md
# Segmented Paging Address Translator

This block turns a 32-bit logical address into a physical address in two steps. The top bits of the address select one of sixteen segment registers held inside the block. Each register holds the start address of that segment's page table in external memory, and a limit on how many page-table entries may be used. The middle bits give the page index. This index is checked against the limit. Only when the page lies inside the limit does the block make a single memory read to fetch the page-table entry. It then checks that entry for presence and write permission, and builds the physical address from the frame number and the untouched page offset.

Software fills the segment registers through a load port, one register per cycle, and reloads the whole set when a different process takes the processor. Only one translation is in flight at a time. A request is accepted when `req_ready` is high. Every accepted request ends in exactly one single-cycle response. That response carries either the physical address or a fault code that names the reason for the refusal.

Top module: `seg_page_xlate`

## Requirements
- R1: The logical address splits as segment = addr[31:28], page index = addr[27:12] and offset = addr[11:0]. The offset passes unchanged into bits [11:0] of the physical address.
- R2: After reset every segment limit is zero, so every request faults with code 1 and makes no memory read. `req_ready` is high after reset.
- R3: A page index greater than or equal to the segment limit faults with code 1. No memory read is issued, and `rsp_valid` rises in the cycle after acceptance. A limit of zero marks an unused segment.
- R4: A page index below the limit issues exactly one read, at address table base + 4 × page index, taken modulo 2^32. The read address is held until `mem_rd_resp`.
- R5: A successful translation returns code 0 with `rsp_paddr` = {entry[31:12], offset}. `rsp_valid` rises in the cycle after the read data is taken.
- R6: Entry bit 0 is the present flag. When it is clear, the request faults with code 2.
- R7: Entry bit 1 allows writes. A write to a present entry with bit 1 clear faults with code 3, while a read of the same entry succeeds.
- R8: Two segments may hold the same table base. Both then translate normally through the same entries.
- R9: A load (`cfg_we`) while a translation is in progress is ignored. A load while idle takes effect for the next request, and `req_ready` is low in any cycle with `cfg_we` high.
- R10: Only one request is in flight. `req_ready` stays low from acceptance through the response cycle, and `rsp_valid` lasts exactly one cycle.
- R11: On any fault, `rsp_paddr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load one segment register |
| cfg_seg | input | 4 | Segment register to load |
| cfg_base | input | 32 | Page-table base address to load |
| cfg_bound | input | 17 | Number of usable page-table entries (0 to 65536) |
| req_valid | input | 1 | Translation request |
| req_write | input | 1 | Request is a write access |
| req_addr | input | 32 | Logical address |
| req_ready | output | 1 | Block can take a request this cycle |
| mem_rd_valid | output | 1 | Page-table read request, held until answered |
| mem_rd_addr | output | 32 | Byte address of the page-table entry |
| mem_rd_resp | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Page-table entry: [31:12] frame, [1] writable, [0] present |
| rsp_valid | output | 1 | Result valid for one cycle |
| rsp_code | output | 2 | 0 ok, 1 limit, 2 not present, 3 write denied |
| rsp_paddr | output | 32 | Physical address, zero on a fault |

## Verification
The assertions assume that memory raises `mem_rd_resp` only while `mem_rd_valid` is high. They also assume that a requester drives `req_valid` for one cycle only when `req_ready` is high. The bench's memory model answers only an outstanding read, after a chosen delay. Each request is raised for exactly one cycle while the block is idle. Loads during a walk are made deliberately, to check that they are dropped.

// File: rtl/spx_pkg.sv
package spx_pkg;
  localparam int ADDR_W      = 32;
  localparam int PRESENT_BIT = 0;
  localparam int WRITE_BIT   = 1;
  localparam int PTE_SHIFT   = 2;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_LIMIT   = 2'd1,
    FLT_ABSENT  = 2'd2,
    FLT_NOWRITE = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_RESP = 2'd2
  } walk_st_e;
endpackage

// File: rtl/spx_seg_file.sv
module spx_seg_file #(
  parameter int SEG_W   = 4,
  parameter int BASE_W  = 32,
  parameter int LIMIT_W = 17
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [SEG_W-1:0]   wr_idx,
  input  logic [BASE_W-1:0]  wr_base,
  input  logic [LIMIT_W-1:0] wr_limit,
  input  logic [SEG_W-1:0]   rd_idx,
  output logic [BASE_W-1:0]  rd_base,
  output logic [LIMIT_W-1:0] rd_limit
);
  localparam int NSEG = 1 << SEG_W;

  logic [BASE_W-1:0]  base_q  [NSEG];
  logic [LIMIT_W-1:0] limit_q [NSEG];

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[g]  <= '0;
        limit_q[g] <= '0;
      end else if (wr_en && (wr_idx == SEG_W'(g))) begin
        base_q[g]  <= wr_base;
        limit_q[g] <= wr_limit;
      end
    end
  end

  assign rd_base  = base_q[rd_idx];
  assign rd_limit = limit_q[rd_idx];
endmodule

// File: rtl/spx_limit_chk.sv
module spx_limit_chk #(
  parameter int PAGE_W = 16
) (
  input  logic [PAGE_W-1:0] page,
  input  logic [PAGE_W:0]   limit,
  output logic              out_of_range
);
  // A zero limit makes every page out of range (unused segment).
  assign out_of_range = ({1'b0, page} >= limit);
endmodule

// File: rtl/spx_walk_fsm.sv
module spx_walk_fsm
  import spx_pkg::*;
#(
  parameter int OFF_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              limit_fail,
  input  logic [ADDR_W-1:0] entry_addr,
  input  logic [OFF_W-1:0]  offset,
  input  logic              is_write,
  input  logic              mem_rd_resp,
  input  logic [ADDR_W-1:0] mem_rd_data,
  output logic              idle,
  output logic              mem_rd_valid,
  output logic [ADDR_W-1:0] mem_rd_addr,
  output logic              rsp_valid,
  output logic [1:0]        rsp_code,
  output logic [ADDR_W-1:0] rsp_paddr
);
  walk_st_e          st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [OFF_W-1:0]  off_q;
  logic              wr_q;
  fault_e            code_q;
  logic [ADDR_W-1:0] pa_q;

  function automatic logic [ADDR_W-1:0] join_frame(
    input logic [ADDR_W-1:0] pte, input logic [OFF_W-1:0] off);
    return {pte[ADDR_W-1:OFF_W], off};
  endfunction

  function automatic fault_e judge(input logic [ADDR_W-1:0] pte, input logic wr);
    if (!pte[PRESENT_BIT])          return FLT_ABSENT;
    else if (wr && !pte[WRITE_BIT]) return FLT_NOWRITE;
    else                            return FLT_NONE;
  endfunction

  logic   unused_pte_bits;
  fault_e verdict;

  assign unused_pte_bits = ^mem_rd_data[OFF_W-1:WRITE_BIT+1];
  assign verdict = judge(mem_rd_data, wr_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      off_q  <= '0;
      wr_q   <= 1'b0;
      code_q <= FLT_NONE;
      pa_q   <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start) begin
          if (limit_fail) begin
            code_q <= FLT_LIMIT;
            pa_q   <= '0;
            st_q   <= ST_RESP;
          end else begin
            addr_q <= entry_addr;
            off_q  <= offset;
            wr_q   <= is_write;
            st_q   <= ST_READ;
          end
        end
        ST_READ: if (mem_rd_resp) begin
          code_q <= verdict;
          pa_q   <= (verdict == FLT_NONE) ? join_frame(mem_rd_data, off_q) : '0;
          st_q   <= ST_RESP;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign idle         = (st_q == ST_IDLE);
  assign mem_rd_valid = (st_q == ST_READ);
  assign mem_rd_addr  = addr_q;
  assign rsp_valid    = (st_q == ST_RESP);
  assign rsp_code     = code_q;
  assign rsp_paddr    = pa_q;
endmodule

// File: rtl/seg_page_xlate.sv
module seg_page_xlate
  import spx_pkg::*;
#(
  parameter int SEG_W  = 4,
  parameter int PAGE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEG_W-1:0]  cfg_seg,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [PAGE_W:0]   cfg_bound,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              mem_rd_valid,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_resp,
  input  logic [ADDR_W-1:0] mem_rd_data,
  output logic              rsp_valid,
  output logic [1:0]        rsp_code,
  output logic [ADDR_W-1:0] rsp_paddr
);
  localparam int OFF_W   = ADDR_W - SEG_W - PAGE_W;
  localparam int LIMIT_W = PAGE_W + 1;

  function automatic logic [ADDR_W-1:0] entry_location(
    input logic [ADDR_W-1:0] base, input logic [PAGE_W-1:0] page);
    return base + (ADDR_W'(page) << PTE_SHIFT);
  endfunction

  logic [SEG_W-1:0]   seg_idx;
  logic [PAGE_W-1:0]  page_idx;
  logic [OFF_W-1:0]   page_off;
  logic [ADDR_W-1:0]  seg_base;
  logic [LIMIT_W-1:0] seg_limit;
  logic               fsm_idle;
  // Named events used by the checker
  logic               acc_fire;
  logic               limit_fail;
  logic               load_taken;

  assign seg_idx  = req_addr[ADDR_W-1 -: SEG_W];
  assign page_idx = req_addr[OFF_W +: PAGE_W];
  assign page_off = req_addr[OFF_W-1:0];

  assign req_ready  = fsm_idle && !cfg_we;
  assign acc_fire   = req_valid && req_ready;
  assign load_taken = cfg_we && fsm_idle;

  spx_seg_file #(.SEG_W(SEG_W), .BASE_W(ADDR_W), .LIMIT_W(LIMIT_W)) u_segs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (load_taken),
    .wr_idx   (cfg_seg),
    .wr_base  (cfg_base),
    .wr_limit (cfg_bound),
    .rd_idx   (seg_idx),
    .rd_base  (seg_base),
    .rd_limit (seg_limit)
  );

  spx_limit_chk #(.PAGE_W(PAGE_W)) u_limit (
    .page         (page_idx),
    .limit        (seg_limit),
    .out_of_range (limit_fail)
  );

  spx_walk_fsm #(.OFF_W(OFF_W)) u_walk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (acc_fire),
    .limit_fail   (limit_fail),
    .entry_addr   (entry_location(seg_base, page_idx)),
    .offset       (page_off),
    .is_write     (req_write),
    .mem_rd_resp  (mem_rd_resp),
    .mem_rd_data  (mem_rd_data),
    .idle         (fsm_idle),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_addr  (mem_rd_addr),
    .rsp_valid    (rsp_valid),
    .rsp_code     (rsp_code),
    .rsp_paddr    (rsp_paddr)
  );
endmodule

// File: rtl/spx_checker.sv
module spx_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_fire,
  input logic        limit_fail,
  input logic        load_taken,
  input logic        req_ready,
  input logic        mem_rd_valid,
  input logic        mem_rd_resp,
  input logic [31:0] mem_rd_addr,
  input logic        rsp_valid,
  input logic [1:0]  rsp_code,
  input logic [31:0] rsp_paddr
);
  a_r3_limit_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire && limit_fail |=> rsp_valid && rsp_code == 2'd1 && !mem_rd_valid);

  a_r4_read_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_resp |=> mem_rd_valid && $stable(mem_rd_addr));

  a_r4_walk_reads: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire && !limit_fail |=> mem_rd_valid);

  a_r5_resp_after_data: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && mem_rd_resp |=> rsp_valid);

  a_r9_load_not_with_req: assert property (@(posedge clk) disable iff (!rst_n)
    load_taken |-> !acc_fire);

  a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || mem_rd_valid) |-> !req_ready);

  a_r10_one_cycle_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_valid, mem_rd_valid}));

  a_r11_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_code != 2'd0 |-> rsp_paddr == 32'd0);
endmodule

bind seg_page_xlate spx_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .acc_fire     (acc_fire),
  .limit_fail   (limit_fail),
  .load_taken   (load_taken),
  .req_ready    (req_ready),
  .mem_rd_valid (mem_rd_valid),
  .mem_rd_resp  (mem_rd_resp),
  .mem_rd_addr  (mem_rd_addr),
  .rsp_valid    (rsp_valid),
  .rsp_code     (rsp_code),
  .rsp_paddr    (rsp_paddr)
);

// File: tb/seg_page_xlate_tb.sv
`timescale 1ns/1ps
module seg_page_xlate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_seg = '0;
  logic [31:0] cfg_base = '0;
  logic [16:0] cfg_bound = '0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_ready;
  logic        mem_rd_valid;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_resp = 1'b0;
  logic [31:0] mem_rd_data = '0;
  logic        rsp_valid;
  logic [1:0]  rsp_code;
  logic [31:0] rsp_paddr;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  seg_page_xlate u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_seg(cfg_seg),
    .cfg_base(cfg_base), .cfg_bound(cfg_bound), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_ready(req_ready),
    .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
    .mem_rd_resp(mem_rd_resp), .mem_rd_data(mem_rd_data),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_paddr(rsp_paddr)
  );

  // Page-table memory model: word index = byte address [11:2]
  logic [31:0] pt_mem [1024];
  int          lat = 0;
  int          wait_cnt = 0;
  int          n_reads = 0;
  logic [31:0] last_rd_addr = '0;

  always @(negedge clk) begin
    if (mem_rd_valid) begin
      if (wait_cnt >= lat) begin
        mem_rd_resp  = 1'b1;
        mem_rd_data  = pt_mem[mem_rd_addr[11:2]];
        last_rd_addr = mem_rd_addr;
        n_reads++;
        wait_cnt = 0;
      end else begin
        mem_rd_resp = 1'b0;
        wait_cnt++;
      end
    end else begin
      mem_rd_resp = 1'b0;
      wait_cnt = 0;
    end
  end

  // Entry: frame in [31:12], writable bit 1, present bit 0
  function automatic logic [31:0] mk_pte(input logic [19:0] frame, input logic w, input logic p);
    return {frame, 10'd0, w, p};
  endfunction

  function automatic logic [31:0] exp_paddr(input logic [19:0] frame, input logic [31:0] la);
    return {frame, la[11:0]};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [1:0]  r_code;
  logic [31:0] r_pa;
  int          r_reads;
  int          r_lat;

  task automatic load_seg(input logic [3:0] s, input logic [31:0] b, input logic [16:0] lim);
    @(negedge clk);
    cfg_we = 1'b1; cfg_seg = s; cfg_base = b; cfg_bound = lim;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_rsp(input int start_reads);
    int cyc = 1;
    while (!rsp_valid && cyc < 60) begin
      @(negedge clk);
      cyc++;
    end
    r_code  = rsp_code;
    r_pa    = rsp_paddr;
    r_lat   = rsp_valid ? cyc : -1;
    r_reads = n_reads - start_reads;
  endtask

  task automatic xlate(input logic [31:0] a, input logic w);
    int s = n_reads;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w;
    @(negedge clk);
    req_valid = 1'b0;
    wait_rsp(s);
  endtask

  task automatic t_reset();
    check(req_ready === 1'b1, "R2 ready after reset", 32'(req_ready), 32'd1);
    xlate(32'h5000_0010, 1'b0);
    check(r_code == 2'd1, "R2 code after reset", 32'(r_code), 32'd1);
    check(r_reads == 0, "R2 no read after reset", 32'(r_reads), 32'd0);
    check(r_pa == 32'd0, "R11 zero paddr on fault", r_pa, 32'd0);
  endtask

  task automatic t_basic_read();
    lat = 0;
    xlate(32'h0000_0070, 1'b0);
    check(r_code == 2'd0, "R5 code", 32'(r_code), 32'd0);
    check(r_pa == exp_paddr(20'h00007, 32'h70), "R1 R5 paddr", r_pa, exp_paddr(20'h00007, 32'h70));
    check(last_rd_addr == 32'h100, "R4 entry address page0", last_rd_addr, 32'h100);
    check(r_reads == 1, "R4 one read", 32'(r_reads), 32'd1);
    check(r_lat == 2, "R5 response timing", 32'(r_lat), 32'd2);
  endtask

  task automatic t_write_perm();
    xlate(32'h0000_1ABC, 1'b1);
    check(r_code == 2'd3, "R7 write denied", 32'(r_code), 32'd3);
    check(r_pa == 32'd0, "R11 zero paddr on write fault", r_pa, 32'd0);
    xlate(32'h0000_1ABC, 1'b0);
    check(r_code == 2'd0 && r_pa == 32'h0000_DABC, "R7 read of read-only page", r_pa, 32'h0000_DABC);
    xlate(32'h0000_0FF0, 1'b1);
    check(r_code == 2'd0 && r_pa == 32'h0000_7FF0, "R7 write to writable page", r_pa, 32'h0000_7FF0);
  endtask

  task automatic t_limit();
    xlate(32'h0000_2000, 1'b0);
    check(r_code == 2'd1, "R3 page equal to limit", 32'(r_code), 32'd1);
    check(r_reads == 0, "R3 no memory read", 32'(r_reads), 32'd0);
    check(r_lat == 1, "R3 response next cycle", 32'(r_lat), 32'd1);
    xlate(32'h3000_0000, 1'b0);
    check(r_code == 2'd1 && r_reads == 0, "R3 unused segment", 32'(r_code), 32'd1);
  endtask

  task automatic t_absent_and_split();
    lat = 2;
    xlate(32'h2000_1234, 1'b0);
    check(r_code == 2'd2, "R6 not present", 32'(r_code), 32'd2);
    check(r_pa == 32'd0, "R11 zero paddr absent", r_pa, 32'd0);
    xlate(32'h2000_2FFF, 1'b1);
    check(r_pa == 32'h1234_5FFF && r_code == 2'd0, "R1 split seg2 page2", r_pa, 32'h1234_5FFF);
    check(last_rd_addr == 32'h208, "R4 entry address seg2 page2", last_rd_addr, 32'h208);
    check(r_lat == 4, "R5 timing with delay", 32'(r_lat), 32'd4);
  endtask

  task automatic t_shared();
    lat = 1;
    xlate(32'h4000_2001, 1'b0);
    check(r_pa == 32'h1234_5001 && r_code == 2'd0, "R8 shared table", r_pa, 32'h1234_5001);
    check(last_rd_addr == 32'h208, "R8 shared entry address", last_rd_addr, 32'h208);
  endtask

  task automatic t_max_page();
    lat = 3;
    xlate(32'h1FFF_F00C, 1'b0);
    check(last_rd_addr == 32'h0003_FFFC, "R4 top page address", last_rd_addr, 32'h0003_FFFC);
    check(r_pa == 32'hABCD_E00C && r_code == 2'd0, "R4 top page translated", r_pa, 32'hABCD_E00C);
  endtask

  task automatic t_load_busy();
    int s;
    lat = 5;
    s = n_reads;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h2000_0010; req_write = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready === 1'b0, "R10 not ready during walk", 32'(req_ready), 32'd0);
    cfg_we = 1'b1; cfg_seg = 4'd2; cfg_base = 32'h0; cfg_bound = 17'd0;
    @(negedge clk);
    cfg_we = 1'b0;
    wait_rsp(s);
    check(r_pa == 32'h0000_3010 && r_code == 2'd0, "R9 walk during load", r_pa, 32'h0000_3010);
    lat = 0;
    xlate(32'h2000_0010, 1'b0);
    check(r_code == 2'd0 && r_reads == 1, "R9 busy load ignored", 32'(r_code), 32'd0);
    @(negedge clk);
    cfg_we = 1'b1; cfg_seg = 4'd2; cfg_base = 32'h0; cfg_bound = 17'd0;
    #1;
    check(req_ready === 1'b0, "R9 not ready while loading", 32'(req_ready), 32'd0);
    @(negedge clk);
    cfg_we = 1'b0;
    xlate(32'h2000_0010, 1'b0);
    check(r_code == 2'd1 && r_reads == 0, "R9 idle load applied", 32'(r_code), 32'd1);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) pt_mem[i] = 32'd0;
    pt_mem[64]   = mk_pte(20'h00007, 1'b1, 1'b1);
    pt_mem[65]   = mk_pte(20'h0000D, 1'b0, 1'b1);
    pt_mem[128]  = mk_pte(20'h00003, 1'b1, 1'b1);
    pt_mem[129]  = mk_pte(20'h00009, 1'b1, 1'b0);
    pt_mem[130]  = mk_pte(20'h12345, 1'b1, 1'b1);
    pt_mem[1023] = mk_pte(20'hABCDE, 1'b0, 1'b1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    load_seg(4'd0, 32'h0000_0100, 17'd2);
    load_seg(4'd1, 32'h0000_0000, 17'h10000);
    load_seg(4'd2, 32'h0000_0200, 17'd4);
    load_seg(4'd4, 32'h0000_0200, 17'd4);
    t_basic_read();
    t_write_perm();
    t_limit();
    t_absent_and_split();
    t_shared();
    t_max_page();
    t_load_busy();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule